// File: doc/BRIEF.md
# Switched Integrator Timing Sequencer

This block sequences an external switched-capacitor current integrator. The integrator has an input switch, which connects the sensor to the integrating capacitor, and a reset switch, which discharges that capacitor. The block drives both switch controls as active-low outputs and repeats a four-phase measurement cycle: discharge, a hold before integration, integration, and a hold after integration. It asks an external converter for one sample in each hold. It then reports the later code minus the earlier code, so that the fixed offset and the charge kicked in when the reset switch opens drop out of the result.

Each phase length is given in clock cycles on input buses. The block takes a snapshot of these buses when a cycle begins, so software can change them at any time. The length of one full cycle is the sum of the four phase lengths, which lets the cycle be set to a line-frequency multiple such as 16.67 ms. A second mode leaves the input switch open all the time, for sensors wired straight to the integrator node. In that mode the integration runs from the end of discharge to the final sample. The converter is modelled as a request pulse that is answered by a done strobe carrying a parallel code.

Top module: `swint_seq`

## Requirements
- R1: After reset, and while no cycle runs, both switch outputs are high (open) and neither the sample request nor the result strobe is asserted.
- R2: The input switch output and the reset switch output are never low in the same cycle, and the input switch closes only after a hold in which both were high.
- R3: In normal mode a running cycle drives the reset switch low for the discharge length, then both high for the pre-hold length, then the input switch low for the integration length, then both high for the post-hold length, and then begins the next cycle directly. The cycle period is the sum of these four lengths.
- R4: A pre-hold length below one microsecond of clock (CLK_HZ/1e6 cycles) is raised to that minimum.
- R5: The first sample request is a one-cycle pulse in the first cycle of the pre-hold.
- R6: In normal mode the second sample request is a one-cycle pulse in post-hold cycle number len_bdelay, counting from 0.
- R7: When both samples of a cycle arrive inside their holds, res_valid pulses for one cycle and res_diff carries {0,B} minus {0,A}, a 17-bit two's-complement value. res_valid rises in the cycle after the done strobe for B is accepted.
- R8: If a hold ends before its done strobe arrives, adc_err is set and that cycle yields no result. adc_err stays set until the next start from idle.
- R9: In simple mode the input switch output stays high. The second request comes in the first cycle of the post-hold, whatever len_bdelay holds, and the result is still the second code minus the first.
- R10: Phase lengths and the mode are captured when a cycle begins. A change to them during a cycle takes effect only from the next cycle.
- R11: A stop pulse ends the sequence at the next clock edge, with both switches open and no further requests.
- R12: A phase length of zero is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins free-running cycles when the block is idle |
| stop | input | 1 | Ends the sequence at once; takes priority over start |
| simple_mode | input | 1 | 1 selects reset-and-integrate with the input switch unused |
| len_reset | input | CW | Discharge length in cycles |
| len_prehold | input | CW | Hold length before integration, in cycles |
| len_integ | input | CW | Integration length in cycles |
| len_posthold | input | CW | Hold length after integration, in cycles |
| len_bdelay | input | CW | Post-hold cycle at which the second sample is requested |
| in_sw_n | output | 1 | Input switch control, low closes |
| rst_sw_n | output | 1 | Reset switch control, low closes |
| adc_req | output | 1 | One-cycle sample request |
| adc_done | input | 1 | Converter done strobe |
| adc_code | input | DW | Converter code, valid with adc_done |
| res_valid | output | 1 | One-cycle result strobe |
| res_diff | output | DW+1 | Second code minus first code |
| adc_err | output | 1 | Sticky flag: a sample missed its hold window |

## Verification
The hardest case to reach is a converter that stays silent for a whole hold, followed by cycles that recover. The bench silences its converter model at an exact cycle boundary. It then checks that the error flag appears without a result, that the flag persists through a later good cycle which still reports, and that only a fresh start clears it. Mid-cycle changes to the length buses are applied a fixed number of cycles into a running cycle, which shows that the change affects the next cycle and not the current one.

// File: rtl/swint_seq.sv
module swint_seq #(
  parameter int CLK_HZ = 50_000_000,
  parameter int CW = 36,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          simple_mode,
  input  logic [CW-1:0] len_reset,
  input  logic [CW-1:0] len_prehold,
  input  logic [CW-1:0] len_integ,
  input  logic [CW-1:0] len_posthold,
  input  logic [CW-1:0] len_bdelay,
  output logic          in_sw_n,
  output logic          rst_sw_n,
  output logic          adc_req,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_code,
  output logic          res_valid,
  output logic [DW:0]   res_diff,
  output logic          adc_err
);

  localparam int MIN_PRE_I = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam logic [CW-1:0] MIN_PRE = CW'(MIN_PRE_I);
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_PRE, S_INT, S_POST} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt, cur;
  logic [CW-1:0] l_rst, l_pre, l_int, l_post, l_bd;
  logic          m_simple, wait_q, got_a, got_b;
  logic [DW-1:0] code_a;
  logic          last, load, in_hold, take, have_a, have_b;
  logic          idle_w;
  logic [31:0]   min_pre_w;

  function automatic logic [CW-1:0] floor_at(input logic [CW-1:0] v, input logic [CW-1:0] m);
    return (v < m) ? m : v;
  endfunction

  always_comb begin
    case (phase)
      S_RST:   cur = l_rst;
      S_PRE:   cur = l_pre;
      S_INT:   cur = l_int;
      S_POST:  cur = l_post;
      default: cur = '0;
    endcase
  end

  assign last     = cnt == cur;
  assign rst_sw_n = phase != S_RST;
  assign in_sw_n  = !(phase == S_INT && !m_simple);
  assign adc_req  = (phase == S_PRE && cnt == '0) ||
                    (phase == S_POST && cnt == (m_simple ? '0 : l_bd));
  assign in_hold  = phase == S_PRE || phase == S_POST;
  assign take     = in_hold && (wait_q || adc_req) && adc_done;
  assign have_a   = got_a || (take && phase == S_PRE);
  assign have_b   = got_b || (take && phase == S_POST);
  assign load     = !stop && ((phase == S_IDLE && start) || (phase == S_POST && last));
  assign idle_w   = phase == S_IDLE;
  assign min_pre_w = 32'(MIN_PRE_I);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rst <= '0; l_pre <= '0; l_int <= '0; l_post <= '0; l_bd <= '0;
      m_simple <= 1'b0;
    end else if (load) begin
      l_rst    <= floor_at(len_reset, ONE) - ONE;
      l_pre    <= floor_at(len_prehold, MIN_PRE) - ONE;
      l_int    <= floor_at(len_integ, ONE) - ONE;
      l_post   <= floor_at(len_posthold, ONE) - ONE;
      l_bd     <= len_bdelay;
      m_simple <= simple_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      cnt       <= '0;
      wait_q    <= 1'b0;
      got_a     <= 1'b0;
      got_b     <= 1'b0;
      code_a    <= '0;
      res_valid <= 1'b0;
      res_diff  <= '0;
      adc_err   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      cnt       <= cnt + ONE;
      if (take) wait_q <= 1'b0;
      else if (adc_req) wait_q <= 1'b1;
      if (take && phase == S_PRE) begin
        code_a <= adc_code;
        got_a  <= 1'b1;
      end
      if (take && phase == S_POST) begin
        got_b <= 1'b1;
        if (got_a) begin
          res_valid <= 1'b1;
          res_diff  <= {1'b0, adc_code} - {1'b0, code_a};
        end
      end
      case (phase)
        S_IDLE: begin
          cnt <= '0;
          if (load) begin
            phase   <= S_RST;
            adc_err <= 1'b0;
          end
        end
        S_RST: if (last) begin
          phase <= S_PRE;
          cnt   <= '0;
        end
        S_PRE: if (last) begin
          if (!have_a) adc_err <= 1'b1;
          wait_q <= 1'b0;
          phase  <= S_INT;
          cnt    <= '0;
        end
        S_INT: if (last) begin
          phase <= S_POST;
          cnt   <= '0;
        end
        S_POST: if (last) begin
          if (!have_b) adc_err <= 1'b1;
          wait_q <= 1'b0;
          got_a  <= 1'b0;
          got_b  <= 1'b0;
          phase  <= S_RST;
          cnt    <= '0;
        end
        default: phase <= S_IDLE;
      endcase
      if (stop) begin
        phase  <= S_IDLE;
        cnt    <= '0;
        wait_q <= 1'b0;
        got_a  <= 1'b0;
        got_b  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/swint_seq_chk.sv
module swint_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_sw_n,
  input logic        rst_sw_n,
  input logic        adc_req,
  input logic        res_valid,
  input logic        idle,
  input logic        simple_q,
  input logic [31:0] min_pre
);

  logic [31:0] open_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_run <= '0;
    else if (!rst_sw_n) open_run <= '0;
    else if (open_run != '1) open_run <= open_run + 32'd1;
  end

  p_idle_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (in_sw_n && rst_sw_n && !adc_req));

  p_never_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sw_n |-> rst_sw_n);

  p_break_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sw_n) |-> ($past(rst_sw_n) && $past(in_sw_n)));

  p_pre_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sw_n) |-> (open_run >= min_pre));

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |=> !adc_req);

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_simple_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    simple_q |-> in_sw_n);

endmodule

bind swint_seq swint_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_sw_n(in_sw_n), .rst_sw_n(rst_sw_n),
  .adc_req(adc_req), .res_valid(res_valid), .idle(idle_w),
  .simple_q(m_simple), .min_pre(min_pre_w)
);

// File: tb/test_swint_seq.sv
module test_swint_seq;
  localparam int CW = 36;
  localparam int DW = 16;
  localparam int LAT = 3;
  localparam logic [DW-1:0] FILL = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0, simple_mode = 1'b0;
  logic [CW-1:0] len_reset = '0, len_prehold = '0, len_integ = '0, len_posthold = '0, len_bdelay = '0;
  logic in_sw_n, rst_sw_n, adc_req, res_valid, adc_err;
  logic adc_done = 1'b0;
  logic [DW-1:0] adc_code = '0;
  logic [DW:0] res_diff;

  always #10 clk = ~clk;

  swint_seq i_swint_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .simple_mode(simple_mode),
    .len_reset(len_reset), .len_prehold(len_prehold), .len_integ(len_integ),
    .len_posthold(len_posthold), .len_bdelay(len_bdelay),
    .in_sw_n(in_sw_n), .rst_sw_n(rst_sw_n), .adc_req(adc_req),
    .adc_done(adc_done), .adc_code(adc_code),
    .res_valid(res_valid), .res_diff(res_diff), .adc_err(adc_err)
  );

  int checks = 0, fails = 0, n_res = 0;
  bit mute = 1'b0;
  logic [DW-1:0] codes[$];
  logic [DW:0]   exps[$];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic plan(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] d;
    d = {1'b0, b} - {1'b0, a};
    codes.push_back(a);
    codes.push_back(b);
    exps.push_back(d);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && adc_req && !mute) begin
        repeat (LAT) @(negedge clk);
        adc_code = (codes.size() > 0) ? codes.pop_front() : FILL;
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      logic [DW:0] e;
      e = (exps.size() > 0) ? exps.pop_front() : '0;
      n_res++;
      chk("R7 diff", longint'($signed(res_diff)), longint'($signed(e)));
    end
  end

  task automatic meas_sw(input int er, input int ep, input int ei, input int eh,
                         input int ed, input string tag);
    int n = 0, p = 0, i = 0, h = 0, areq = -1, breq = -1, both = 0;
    while (rst_sw_n) @(negedge clk);
    while (!rst_sw_n) begin
      if (!in_sw_n) both++;
      n++;
      @(negedge clk);
    end
    while (in_sw_n && rst_sw_n) begin
      if (adc_req && areq < 0) areq = p;
      p++;
      @(negedge clk);
    end
    while (!in_sw_n) begin
      if (!rst_sw_n) both++;
      i++;
      @(negedge clk);
    end
    while (rst_sw_n) begin
      if (adc_req && breq < 0) breq = h;
      h++;
      @(negedge clk);
    end
    chk({tag, " R3 discharge"}, n, er);
    chk({tag, " R3 prehold"}, p, ep);
    chk({tag, " R3 integrate"}, i, ei);
    chk({tag, " R3 posthold"}, h, eh);
    chk("R5 first request", areq, 0);
    chk("R6 second request", breq, ed);
    chk("R2 overlap", both, 0);
  endtask

  task automatic meas_simple(input int er, input int ep, input int ei, input int eh);
    int n = 0, t = 0, a = -1, b = -1, low = 0;
    while (rst_sw_n) @(negedge clk);
    while (!rst_sw_n) begin
      n++;
      @(negedge clk);
    end
    while (rst_sw_n) begin
      if (adc_req) begin
        if (a < 0) a = t;
        else if (b < 0) b = t;
      end
      if (!in_sw_n) low++;
      t++;
      @(negedge clk);
    end
    chk("R9 discharge", n, er);
    chk("R9 first request", a, 0);
    chk("R9 second request", b, ep + ei);
    chk("R9 input switch", low, 0);
    chk("R9 open span", t, ep + ei + eh);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int snap;
    int quiet;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_sw_n", in_sw_n, 1);
    chk("R1 rst_sw_n", rst_sw_n, 1);
    chk("R1 adc_req", adc_req, 0);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 adc_err", adc_err, 0);

    len_reset = 10; len_prehold = 60; len_integ = 100; len_posthold = 40; len_bdelay = 5;
    plan(16'd1000, 16'd1500);
    plan(16'd3000, 16'd100);
    plan(16'd0, 16'd65535);
    plan(16'd65535, 16'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) meas_sw(10, 60, 100, 40, 5, "R3");
    chk("R7 results", n_res, 4);

    fork
      meas_sw(10, 60, 100, 40, 5, "R10 current");
      begin
        repeat (20) @(negedge clk);
        len_integ = 150;
      end
    join
    meas_sw(10, 60, 150, 40, 5, "R10 next");

    len_reset = 0; len_prehold = 3;
    meas_sw(10, 60, 150, 40, 5, "R10 held");
    meas_sw(1, 50, 150, 40, 5, "R4 R12");

    mute = 1'b1;
    snap = n_res;
    meas_sw(1, 50, 150, 40, 5, "R8 muted");
    mute = 1'b0;
    chk("R8 error set", adc_err, 1);
    chk("R8 no result", n_res, snap);
    meas_sw(1, 50, 150, 40, 5, "R8 recover");
    chk("R8 error sticky", adc_err, 1);
    chk("R7 result after recovery", n_res, snap + 1);

    repeat (1 + 50 + 5) @(negedge clk);
    chk("R3 integrating", in_sw_n, 0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R11 in_sw_n", in_sw_n, 1);
    chk("R11 rst_sw_n", rst_sw_n, 1);
    quiet = 0;
    for (int k = 0; k < 20; k++) begin
      if (!in_sw_n || !rst_sw_n || adc_req) quiet++;
      @(negedge clk);
    end
    chk("R11 stays idle", quiet, 0);

    simple_mode = 1'b1;
    len_reset = 10; len_prehold = 60; len_integ = 100; len_posthold = 40; len_bdelay = 7;
    plan(16'd200, 16'd700);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 error cleared by start", adc_err, 0);
    meas_simple(10, 60, 100, 40);
    meas_simple(10, 60, 100, 40);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 planned results consumed", exps.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule